// File: doc/BRIEF.md
# USB Endpoint Command and Status Unit

This block sits between a processor and the endpoint buffer memory of a USB device controller. The processor drives a 16-bit bus with write and read strobes and one select line. With the select line high, a write carries a command. With it low, the strobe moves one data word. A command picks an endpoint and an action: fill its buffer, drain its buffer, or fetch its status byte. The data words that follow stream through a per-endpoint word pointer. A buffer transfer always opens with the packet length word.

Each endpoint keeps a 7-bit status record, read as an 8-bit byte, and one interrupt bit. The serial engine reports stall and unstall requests, received setup tokens and completed transactions on plain strobes that share one endpoint index. Endpoints listed in a double-buffer mask own a primary and a secondary buffer. While DMA mode is on, a stream on such an endpoint leaves the end of the primary buffer and continues at the start of the secondary buffer without a new command.

Top module: `ep_cmd_unit`

## Requirements
- R1: A write with `cmd_sel` high is a command. Only bits 7:0 are decoded. Bits 7:4 are the group: 0h selects a buffer write, 1h a buffer read and 5h a status read. Bits 3:0 are the endpoint. An unknown group, or an endpoint at or above NUM_EP, leaves the unit idle. While idle, data strobes change nothing and `bus_rdata` is 0.
- R2: After a buffer-write command, the first data write stores the packet length. Each later data write stores one word at the pointer and then advances the pointer. A word holds the earlier byte in bits 7:0 and the later byte in bits 15:8.
- R3: After a buffer-read command, `bus_rdata` first shows the stored length. Each read strobe then moves on, and the stored words come out in the order they were written.
- R4: After a status command, `bus_rdata` shows {8'h00, status}. Status bit 7 is stall, bit 6 secondary full, bit 5 primary full, bit 4 next data PID (0 = DATA0, 1 = DATA1), bit 3 setup overwrite, bit 2 last packet was setup, bit 1 buffer in use (0 = primary, 1 = secondary), and bit 0 always 0. One read strobe ends the phase, and `bus_rdata` returns to 0.
- R5: The read strobe of a status phase clears that endpoint's `irq_vec` bit and leaves the others alone. If a completion for the same endpoint arrives in that cycle, the completion wins.
- R6: `evt_stall` sets bit 7. `evt_unstall` or `evt_setup` clears it, and wins over `evt_stall` in the same cycle.
- R7: `evt_setup` copies the previous primary-full flag into bit 3, then sets bit 2 and bit 5. `evt_done` clears bit 2.
- R8: `evt_done` sets the full flag of the buffer in use, toggles bit 4 and sets the endpoint's `irq_vec` bit. On a double-buffered endpoint it also flips bit 1.
- R9: With `dma_mode` high, on a double-buffered endpoint in its primary buffer, the stream moves to word 0 of the secondary buffer after the last primary word. This applies to reads and writes. Bit 1 of the status becomes 1.
- R10: In every other case the pointer wraps to word 0 of the same buffer after the last word. There is no check of bounds or direction.
- R11: During and right after reset, every status bit and every `irq_vec` bit is 0, the unit is idle and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| cmd_sel | input | 1 | 1 = command phase, 0 = data phase |
| bus_wdata | input | 16 | Write data or command code |
| bus_rdata | output | 16 | Read data for the current phase |
| dma_mode | input | 1 | Enables the primary-to-secondary switch |
| evt_stall | input | 1 | Stall request for `evt_ep` |
| evt_unstall | input | 1 | Unstall request for `evt_ep` |
| evt_setup | input | 1 | Setup token received on `evt_ep` |
| evt_done | input | 1 | Transaction complete on `evt_ep` |
| evt_ep | input | $clog2(NUM_EP) | Endpoint index for the event strobes |
| irq_vec | output | NUM_EP | Per-endpoint interrupt bits |

## Verification
The bench builds the unit with NUM_EP = 4, BUF_WORDS = 4 and only endpoint 2 double-buffered. With four-word buffers, the primary-to-secondary switch and the wrap at the end of a buffer come up after a handful of strobes. The mask puts single- and double-buffered endpoints side by side, so the same strobe sequence must switch on one endpoint and wrap on another. With four endpoints, every status and interrupt bit stays in view of the model on every cycle.

// File: rtl/ep_cmd_pkg.sv
package ep_cmd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WLEN,
    PH_WDATA,
    PH_RLEN,
    PH_RDATA,
    PH_RSTAT
  } phase_e;

  // Status record, bits 7..1 of the status byte (bit 0 is constant zero)
  typedef struct packed {
    logic stall;
    logic full_sec;
    logic full_pri;
    logic pid;
    logic ovw;
    logic setup;
    logic cur_buf;
  } ep_stat_t;

  localparam logic [3:0] GRP_BUF_WR = 4'h0;
  localparam logic [3:0] GRP_BUF_RD = 4'h1;
  localparam logic [3:0] GRP_STAT   = 4'h5;

endpackage

// File: rtl/ep_buf_mem.sv
module ep_buf_mem #(
  parameter int NUM_EP    = 16,
  parameter int BUF_WORDS = 32,
  parameter int DW        = 16,
  localparam int EPW      = $clog2(NUM_EP),
  localparam int PW       = $clog2(BUF_WORDS)
) (
  input  logic           clk,
  input  logic           word_we,
  input  logic           len_we,
  input  logic [EPW-1:0] ep,
  input  logic           bsel,
  input  logic [PW-1:0]  ptr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_word,
  output logic [DW-1:0]  rd_len
);
  localparam int AW     = EPW + 1 + PW;
  localparam int DEPTH  = NUM_EP * 2 * BUF_WORDS;
  localparam int NBUF   = NUM_EP * 2;

  logic [DW-1:0] words [DEPTH];
  logic [DW-1:0] lens  [NBUF];

  logic [AW-1:0]  waddr;
  logic [EPW:0]   laddr;

  assign waddr = {ep, bsel, ptr};
  assign laddr = {ep, bsel};

  // storage array: no reset, written only under its enables
  always_ff @(posedge clk) begin
    if (word_we) words[waddr] <= wdata;
    if (len_we)  lens[laddr]  <= wdata;
  end

  assign rd_word = words[waddr];
  assign rd_len  = lens[laddr];

endmodule

// File: rtl/ep_status_bank.sv
module ep_status_bank
  import ep_cmd_pkg::*;
#(
  parameter int                 NUM_EP   = 16,
  parameter logic [NUM_EP-1:0]  DBL_MASK = '1,
  localparam int                EPW      = $clog2(NUM_EP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_stall,
  input  logic                   evt_unstall,
  input  logic                   evt_setup,
  input  logic                   evt_done,
  input  logic [EPW-1:0]         evt_ep,
  input  logic                   stat_rd,
  input  logic [EPW-1:0]         stat_ep,
  input  logic                   sw_set,
  input  logic [EPW-1:0]         sw_ep,
  output ep_stat_t [NUM_EP-1:0]  stat_q,
  output logic [NUM_EP-1:0]      irq_q
);
  ep_stat_t [NUM_EP-1:0] stat_d;
  logic [NUM_EP-1:0]     irq_d;
  logic                  upd_en;

  assign upd_en = evt_stall | evt_unstall | evt_setup | evt_done | stat_rd | sw_set;

  always_comb begin
    stat_d = stat_q;
    irq_d  = irq_q;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sw_set && sw_ep == EPW'(i))
        stat_d[i].cur_buf = 1'b1;
      if (evt_done && evt_ep == EPW'(i)) begin
        if (stat_q[i].cur_buf) stat_d[i].full_sec = 1'b1;
        else                   stat_d[i].full_pri = 1'b1;
        stat_d[i].pid   = ~stat_q[i].pid;
        stat_d[i].setup = 1'b0;
        if (DBL_MASK[i]) stat_d[i].cur_buf = ~stat_q[i].cur_buf;
        irq_d[i] = 1'b1;
      end
      if (evt_setup && evt_ep == EPW'(i)) begin
        stat_d[i].ovw      = stat_q[i].full_pri;
        stat_d[i].setup    = 1'b1;
        stat_d[i].full_pri = 1'b1;
      end
      if (evt_stall && evt_ep == EPW'(i))
        stat_d[i].stall = 1'b1;
      if ((evt_unstall || evt_setup) && evt_ep == EPW'(i))
        stat_d[i].stall = 1'b0;
      if (stat_rd && stat_ep == EPW'(i) && !(evt_done && evt_ep == EPW'(i)))
        irq_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= '0;
    end else if (upd_en) begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

endmodule

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_cmd_pkg::*;
#(
  parameter int                 NUM_EP    = 16,
  parameter int                 BUF_WORDS = 32,
  parameter logic [NUM_EP-1:0]  DBL_MASK  = '1,
  localparam int                EPW       = $clog2(NUM_EP),
  localparam int                PW        = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              cmd_sel,
  input  logic [15:0]       bus_wdata,
  input  logic              dma_mode,
  input  logic [NUM_EP-1:0] cur_buf_vec,
  output phase_e            phase_q,
  output logic [EPW-1:0]    sel_ep_q,
  output logic              sel_buf_q,
  output logic [PW-1:0]     ptr_q,
  output logic              word_we,
  output logic              len_we,
  output logic              stat_rd,
  output logic              sw_set,
  output logic              adv
);
  localparam logic [PW-1:0] PTR_LAST = PW'(BUF_WORDS - 1);

  phase_e          phase_d;
  logic [EPW-1:0]  sel_ep_d;
  logic            sel_buf_d;
  logic [PW-1:0]   ptr_d;
  logic [7:0]      code;
  logic [EPW-1:0]  code_ep;
  logic            code_ep_ok;
  logic            cmd_wr, dat_wr, dat_rd;
  logic            reg_en;

  assign cmd_wr     = bus_wr & cmd_sel;
  assign dat_wr     = bus_wr & ~cmd_sel;
  assign dat_rd     = bus_rd & ~bus_wr & ~cmd_sel;
  assign code       = bus_wdata[7:0];
  assign code_ep    = code[EPW-1:0];
  assign code_ep_ok = int'(code[3:0]) < NUM_EP;
  assign reg_en     = bus_wr | bus_rd;

  always_comb begin
    phase_d   = phase_q;
    sel_ep_d  = sel_ep_q;
    sel_buf_d = sel_buf_q;
    ptr_d     = ptr_q;
    word_we   = 1'b0;
    len_we    = 1'b0;
    stat_rd   = 1'b0;
    sw_set    = 1'b0;
    adv       = 1'b0;
    if (cmd_wr) begin
      sel_ep_d  = code_ep;
      sel_buf_d = DBL_MASK[code_ep] & cur_buf_vec[code_ep];
      ptr_d     = '0;
      phase_d   = PH_IDLE;
      if (code_ep_ok) begin
        unique case (code[7:4])
          GRP_BUF_WR: phase_d = PH_WLEN;
          GRP_BUF_RD: phase_d = PH_RLEN;
          GRP_STAT:   phase_d = PH_RSTAT;
          default:    phase_d = PH_IDLE;
        endcase
      end
    end else if (dat_wr && phase_q == PH_WLEN) begin
      len_we  = 1'b1;
      phase_d = PH_WDATA;
    end else if (dat_wr && phase_q == PH_WDATA) begin
      word_we = 1'b1;
      adv     = 1'b1;
    end else if (dat_rd && phase_q == PH_RLEN) begin
      phase_d = PH_RDATA;
    end else if (dat_rd && phase_q == PH_RDATA) begin
      adv = 1'b1;
    end else if (dat_rd && phase_q == PH_RSTAT) begin
      stat_rd = 1'b1;
      phase_d = PH_IDLE;
    end

    if (adv) begin
      if (ptr_q == PTR_LAST) begin
        ptr_d = '0;
        if (dma_mode && DBL_MASK[sel_ep_q] && !sel_buf_q) begin
          sel_buf_d = 1'b1;
          sw_set    = 1'b1;
        end
      end else begin
        ptr_d = ptr_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      sel_ep_q  <= '0;
      sel_buf_q <= 1'b0;
      ptr_q     <= '0;
    end else if (reg_en) begin
      phase_q   <= phase_d;
      sel_ep_q  <= sel_ep_d;
      sel_buf_q <= sel_buf_d;
      ptr_q     <= ptr_d;
    end
  end

endmodule

// File: rtl/ep_cmd_unit.sv
module ep_cmd_unit
  import ep_cmd_pkg::*;
#(
  parameter int                 NUM_EP    = 16,
  parameter int                 BUF_WORDS = 32,
  parameter logic [NUM_EP-1:0]  DBL_MASK  = '1,
  localparam int                EPW       = $clog2(NUM_EP),
  localparam int                PW        = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              cmd_sel,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              dma_mode,
  input  logic              evt_stall,
  input  logic              evt_unstall,
  input  logic              evt_setup,
  input  logic              evt_done,
  input  logic [EPW-1:0]    evt_ep,
  output logic [NUM_EP-1:0] irq_vec
);
  phase_e                phase_q;
  logic [EPW-1:0]        sel_ep_q;
  logic                  sel_buf_q;
  logic [PW-1:0]         ptr_q;
  logic                  word_we, len_we, stat_rd, sw_set, adv;
  ep_stat_t [NUM_EP-1:0] stat_q;
  logic [NUM_EP-1:0]     cur_buf_vec;
  logic [NUM_EP-1:0]     stall_vec;
  logic [15:0]           rd_word, rd_len;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_vec
    assign cur_buf_vec[g] = stat_q[g].cur_buf;
    assign stall_vec[g]   = stat_q[g].stall;
  end

  ep_cmd_decode #(
    .NUM_EP(NUM_EP), .BUF_WORDS(BUF_WORDS), .DBL_MASK(DBL_MASK)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .cmd_sel(cmd_sel), .bus_wdata(bus_wdata), .dma_mode(dma_mode),
    .cur_buf_vec(cur_buf_vec), .phase_q(phase_q), .sel_ep_q(sel_ep_q),
    .sel_buf_q(sel_buf_q), .ptr_q(ptr_q), .word_we(word_we),
    .len_we(len_we), .stat_rd(stat_rd), .sw_set(sw_set), .adv(adv)
  );

  ep_status_bank #(
    .NUM_EP(NUM_EP), .DBL_MASK(DBL_MASK)
  ) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_stall(evt_stall),
    .evt_unstall(evt_unstall), .evt_setup(evt_setup), .evt_done(evt_done),
    .evt_ep(evt_ep), .stat_rd(stat_rd), .stat_ep(sel_ep_q),
    .sw_set(sw_set), .sw_ep(sel_ep_q), .stat_q(stat_q), .irq_q(irq_vec)
  );

  ep_buf_mem #(
    .NUM_EP(NUM_EP), .BUF_WORDS(BUF_WORDS), .DW(16)
  ) u_mem (
    .clk(clk), .word_we(word_we), .len_we(len_we), .ep(sel_ep_q),
    .bsel(sel_buf_q), .ptr(ptr_q), .wdata(bus_wdata),
    .rd_word(rd_word), .rd_len(rd_len)
  );

  always_comb begin
    unique case (phase_q)
      PH_RLEN:  bus_rdata = rd_len;
      PH_RDATA: bus_rdata = rd_word;
      PH_RSTAT: bus_rdata = {8'h00, stat_q[sel_ep_q], 1'b0};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ep_cmd_chk.sv
module ep_cmd_chk #(
  parameter int NUM_EP    = 16,
  parameter int BUF_WORDS = 32,
  localparam int EPW      = $clog2(NUM_EP),
  localparam int PW       = $clog2(BUF_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_unstall,
  input logic              evt_setup,
  input logic              evt_done,
  input logic [EPW-1:0]    evt_ep,
  input logic [NUM_EP-1:0] irq_vec,
  input logic              stat_rd,
  input logic [EPW-1:0]    sel_ep_q,
  input logic              sel_buf_q,
  input logic [PW-1:0]     ptr_q,
  input logic              sw_set,
  input logic              adv,
  input logic [NUM_EP-1:0] cur_buf_vec,
  input logic [NUM_EP-1:0] stall_vec
);
  localparam logic [PW-1:0] PTR_LAST = PW'(BUF_WORDS - 1);

  // R11
  irq_reset_chk: assert property (@(posedge clk) !rst_n |-> irq_vec == '0);

  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> irq_vec[$past(evt_ep)]);

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(evt_done && evt_ep == sel_ep_q)) |=> !irq_vec[$past(sel_ep_q)]);

  // R6
  unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_unstall || evt_setup) |=> !stall_vec[$past(evt_ep)]);

  // R9
  auto_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !evt_done) |=> (cur_buf_vec[$past(sel_ep_q)] && sel_buf_q && ptr_q == '0));

  // R10
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == PTR_LAST) |=> ptr_q == '0);

endmodule

bind ep_cmd_unit ep_cmd_chk #(.NUM_EP(NUM_EP), .BUF_WORDS(BUF_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_unstall(evt_unstall), .evt_setup(evt_setup),
  .evt_done(evt_done), .evt_ep(evt_ep), .irq_vec(irq_vec), .stat_rd(stat_rd),
  .sel_ep_q(sel_ep_q), .sel_buf_q(sel_buf_q), .ptr_q(ptr_q), .sw_set(sw_set),
  .adv(adv), .cur_buf_vec(cur_buf_vec), .stall_vec(stall_vec)
);

// File: tb/ep_cmd_unit_tb.sv
`timescale 1ns/1ps
module ep_cmd_unit_tb;
  localparam int NE  = 4;
  localparam int BW  = 4;
  localparam logic [NE-1:0] DBL = 4'b0100;
  localparam int EW  = $clog2(NE);

  logic clk, rst_n;
  logic bus_wr, bus_rd, cmd_sel, dma_mode;
  logic [15:0] bus_wdata, bus_rdata;
  logic evt_stall, evt_unstall, evt_setup, evt_done;
  logic [EW-1:0] evt_ep;
  logic [NE-1:0] irq_vec;

  int checks = 0, fails = 0;

  ep_cmd_unit #(.NUM_EP(NE), .BUF_WORDS(BW), .DBL_MASK(DBL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .cmd_sel(cmd_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_mode(dma_mode), .evt_stall(evt_stall), .evt_unstall(evt_unstall),
    .evt_setup(evt_setup), .evt_done(evt_done), .evt_ep(evt_ep),
    .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_ph;            // 0 idle 1 wlen 2 wdata 3 rlen 4 rdata 5 rstat
  int m_ep, m_buf, m_ptr;
  bit m_stall[NE], m_fs[NE], m_fp[NE], m_pid[NE], m_ovw[NE], m_su[NE], m_cb[NE];
  bit m_irq[NE];
  int m_mem[NE*2*BW];
  bit m_mem_ok[NE*2*BW];
  int m_len[NE*2];
  bit m_len_ok[NE*2];

  function automatic int m_status(int e);
    return (int'(m_stall[e]) << 7) | (int'(m_fs[e]) << 6) | (int'(m_fp[e]) << 5) |
           (int'(m_pid[e]) << 4) | (int'(m_ovw[e]) << 3) | (int'(m_su[e]) << 2) |
           (int'(m_cb[e]) << 1);
  endfunction

  function automatic int m_rdata();   // -1 when the expected word is unknown
    int k;
    k = (m_ep*2 + m_buf)*BW + m_ptr;
    case (m_ph)
      3: return m_len_ok[m_ep*2+m_buf] ? m_len[m_ep*2+m_buf] : -1;
      4: return m_mem_ok[k] ? m_mem[k] : -1;
      5: return m_status(m_ep);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int e, oc, of0, code, grp, n, k, rd_ep;
    bit sw, adv, rdclr;
    if (!rst_n) begin
      m_ph = 0; m_ep = 0; m_buf = 0; m_ptr = 0;
      for (int i = 0; i < NE; i++) begin
        m_stall[i] = 0; m_fs[i] = 0; m_fp[i] = 0; m_pid[i] = 0;
        m_ovw[i] = 0; m_su[i] = 0; m_cb[i] = 0; m_irq[i] = 0;
      end
    end else begin
      sw = 0; adv = 0; rdclr = 0; rd_ep = m_ep;
      e = int'(evt_ep); oc = int'(m_cb[e]); of0 = int'(m_fp[e]);
      if (bus_wr && cmd_sel) begin
        code = int'(bus_wdata[7:0]); grp = code / 16; n = code % 16;
        m_ph = 0;
        if (n < NE) begin
          if (grp == 0) m_ph = 1;
          else if (grp == 1) m_ph = 3;
          else if (grp == 5) m_ph = 5;
          m_ep = n; m_buf = DBL[n] ? int'(m_cb[n]) : 0;
        end
        m_ptr = 0;
      end else if (bus_wr) begin
        if (m_ph == 1) begin
          m_len[m_ep*2+m_buf] = int'(bus_wdata); m_len_ok[m_ep*2+m_buf] = 1; m_ph = 2;
        end else if (m_ph == 2) begin
          k = (m_ep*2 + m_buf)*BW + m_ptr;
          m_mem[k] = int'(bus_wdata); m_mem_ok[k] = 1; adv = 1;
        end
      end else if (bus_rd && !cmd_sel) begin
        if (m_ph == 3) m_ph = 4;
        else if (m_ph == 4) adv = 1;
        else if (m_ph == 5) begin rdclr = 1; m_ph = 0; end
      end
      if (adv) begin
        m_ptr++;
        if (m_ptr == BW) begin
          m_ptr = 0;
          if (dma_mode && DBL[m_ep] && m_buf == 0) begin m_buf = 1; sw = 1; end
        end
      end
      if (sw) m_cb[m_ep] = 1;
      if (evt_done) begin
        if (oc != 0) m_fs[e] = 1; else m_fp[e] = 1;
        m_pid[e] = !m_pid[e]; m_su[e] = 0;
        if (DBL[e]) m_cb[e] = (oc == 0);
        m_irq[e] = 1;
      end
      if (evt_setup) begin m_ovw[e] = (of0 != 0); m_su[e] = 1; m_fp[e] = 1; end
      if (evt_stall) m_stall[e] = 1;
      if (evt_unstall || evt_setup) m_stall[e] = 0;
      if (rdclr && !(evt_done && e == rd_ep)) m_irq[rd_ep] = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int x;
      x = m_rdata();
      if (x >= 0) chk(bus_rdata === 16'(x), "R1-model rdata", int'(bus_rdata), x);
      for (int i = 0; i < NE; i++)
        chk(irq_vec[i] === m_irq[i], "R8-model irq", int'(irq_vec[i]), int'(m_irq[i]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic quiet();
    bus_wr = 0; bus_rd = 0; cmd_sel = 0; bus_wdata = '0;
    evt_stall = 0; evt_unstall = 0; evt_setup = 0; evt_done = 0; evt_ep = '0;
  endtask

  task automatic cmd(input logic [15:0] c);
    bus_wr = 1; cmd_sel = 1; bus_wdata = c; @(negedge clk); quiet();
  endtask

  task automatic wr(input logic [15:0] d);
    bus_wr = 1; bus_wdata = d; @(negedge clk); quiet();
  endtask

  task automatic rd(input logic [15:0] exp, input string req);
    chk(bus_rdata === exp, req, int'(bus_rdata), int'(exp));
    bus_rd = 1; @(negedge clk); quiet();
  endtask

  task automatic rd_blind();
    bus_rd = 1; @(negedge clk); quiet();
  endtask

  task automatic evt(input bit s, input bit u, input bit su, input bit d, input int ep);
    evt_stall = s; evt_unstall = u; evt_setup = su; evt_done = d; evt_ep = EW'(ep);
    @(negedge clk); quiet();
  endtask

  task automatic stat(input int ep, input logic [7:0] exp, input string req);
    cmd(16'h0050 | 16'(ep));
    rd({8'h00, exp}, req);
  endtask

  function automatic logic [15:0] pack(input logic [7:0] first, input logic [7:0] second);
    return {second, first};
  endfunction

  initial begin : watchdog
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    quiet(); dma_mode = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(irq_vec === '0, "R11 irq after reset", int'(irq_vec), 0);
    chk(bus_rdata === 16'h0, "R11 rdata in reset", int'(bus_rdata), 0);
    rst_n = 1;
    @(negedge clk);
    stat(1, 8'h00, "R11 status zero after reset");

    // R1 R2 R3: junk in bits 15:8 of command, byte packing, length first
    cmd(16'hA501);
    wr(16'h0006);
    wr(pack(8'h11, 8'h22)); wr(pack(8'h33, 8'h44)); wr(pack(8'h55, 8'h66));
    cmd(16'h0011);
    rd(16'h0006, "R3 length word first");
    rd(16'h2211, "R2 earlier byte low");
    rd(16'h4433, "R3 word order");
    rd(16'h6655, "R3 word order");

    // R1 unknown group and out-of-range endpoint are ignored
    cmd(16'h0031);
    chk(bus_rdata === 16'h0, "R1 idle rdata", int'(bus_rdata), 0);
    wr(16'hDEAD);
    cmd(16'h0007);
    wr(16'hBEEF);
    cmd(16'h0011);
    rd(16'h0006, "R1 ignored data kept length");
    rd(16'h2211, "R1 ignored data kept word");

    // R8 completion, R4 status layout, R5 read clears irq
    evt(0, 0, 0, 1, 1);
    chk(irq_vec[1] === 1'b1, "R8 irq set", int'(irq_vec), 2);
    cmd(16'h0051);
    chk(irq_vec[1] === 1'b1, "R5 irq held until read", int'(irq_vec), 2);
    rd(16'h0030, "R4 full primary and pid");
    chk(irq_vec[1] === 1'b0, "R5 irq cleared by read", int'(irq_vec), 0);
    chk(bus_rdata === 16'h0, "R4 phase over", int'(bus_rdata), 0);
    // R5 completion in same cycle as status read wins
    evt(0, 0, 0, 1, 0);
    evt(0, 0, 0, 1, 1);
    cmd(16'h0051);
    evt_done = 1; evt_ep = EW'(1); bus_rd = 1; @(negedge clk); quiet();
    chk(irq_vec === 4'b0011, "R5 set wins and other ep untouched", int'(irq_vec), 3);

    // R6 stall / unstall / setup
    evt(1, 0, 0, 0, 3);
    stat(3, 8'h80, "R6 stall set");
    evt(0, 1, 0, 0, 3);
    stat(3, 8'h00, "R6 unstall");
    evt(1, 1, 0, 0, 3);
    stat(3, 8'h00, "R6 unstall beats stall");
    evt(1, 0, 0, 0, 3);
    // R7 setup clears stall, sets setup and primary full
    evt(0, 0, 1, 0, 3);
    stat(3, 8'h24, "R7 setup clears stall");
    evt(0, 0, 1, 0, 3);
    stat(3, 8'h2C, "R7 overwrite flagged");
    evt(0, 0, 0, 1, 3);
    stat(3, 8'h38, "R7 done clears setup bit");

    // R9 automatic switch on double-buffered ep2
    dma_mode = 1;
    cmd(16'h0002);
    wr(16'h0008);
    for (int i = 0; i < 8; i++) wr(16'h0A00 + 16'(i));
    stat(2, 8'h02, "R9 secondary in use");
    cmd(16'h0012);
    rd_blind();
    for (int i = 4; i < 8; i++) rd(16'h0A00 + 16'(i), "R9 secondary data");
    rd(16'h0A04, "R10 secondary wraps");
    evt(0, 0, 0, 1, 2);
    stat(2, 8'h50, "R8 done flips buffer on double ep");
    cmd(16'h0012);
    rd(16'h0008, "R9 primary length");
    for (int i = 0; i < 4; i++) rd(16'h0A00 + 16'(i), "R9 primary data");
    rd(16'h0A04, "R9 read stream switches");
    stat(2, 8'h52, "R9 switch on read");

    // R10 single-buffered ep1 wraps even with dma on
    cmd(16'h0001);
    wr(16'h0005);
    for (int i = 0; i < 5; i++) wr(16'h0B00 + 16'(i));
    cmd(16'h0011);
    rd(16'h0005, "R10 length");
    rd(16'h0B04, "R10 overwrite word 0");
    rd(16'h0B01, "R10 word 1 intact");
    stat(1, 8'h30, "R10 no buffer switch");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule